// File: doc/BRIEF.md
# APB Setup/Access Timing Monitor

This block watches an APB bus without driving any of its signals. Every clock it samples the select, enable, ready, address, direction and write-data lines. It keeps track of whether a transfer is open, meaning a setup cycle has been seen and no completion has followed yet. From that it decides whether the current cycle obeys the two-phase setup/access contract.

Each kind of timing fault has its own error class. Every class drives a one-cycle pulse and a sticky status bit, and the sticky bits are cleared by a clear input. The monitor also gives a completion pulse and two saturating counters: one counts completed transfers and the other counts wait cycles. All outputs are registered, so they report a bus cycle on the following clock. The block is intended as a bring-up and integration aid placed beside any APB requester/completer pair.

Top module: `bus_phase_monitor`

## Requirements
- R1: `done_pulse` is high for exactly one cycle, in the cycle after a bus cycle where `sel`, `en` and `rdy` are all high. It is low after every other bus cycle.
- R2: A bus cycle with `sel` and `en` high and `rdy` low is a wait cycle. It produces no completion, and it adds one to `wait_count`.
- R3: Error bit 0 (early enable) pulses when `en` is high in the first cycle of `sel`, with no transfer open and no completion in the previous cycle.
- R4: Error bit 1 (held enable) pulses when `en` is high in the cycle right after a completion. A new setup cycle (`sel` high, `en` low) right after a completion raises no error.
- R5: Error bit 2 (unstable) pulses when, while a transfer is open and `sel` is high, `addr` or `wr` differs from its setup value. It also pulses when `wdata` differs from its setup value on a write. A change of `wdata` during a read has no effect.
- R6: Error bit 3 (short transfer) pulses when a completion occurs with no earlier setup cycle in that transfer, so the transfer took fewer than two cycles.
- R7: Error bit 4 (enable without select) pulses when `en` is high while `sel` is low.
- R8: Error bit 5 (select dropped) pulses when `sel` goes low while a transfer is open and not yet complete.
- R9: Each `err_sticky` bit is set in the same cycle as its `err_pulse` bit and holds until `clr_sticky` is high. If a new error arrives in the same cycle as the clear, the set wins.
- R10: `xfer_count` and `wait_count` stop at their all-ones value and do not wrap.
- R11: While reset is low, and right after it is released, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus select being observed |
| en | input | 1 | Bus enable being observed |
| rdy | input | 1 | Completer ready being observed |
| addr | input | ADDR_W | Bus address being observed |
| wr | input | 1 | Bus direction being observed (1 = write) |
| wdata | input | DATA_W | Bus write data being observed |
| clr_sticky | input | 1 | Clears all sticky error bits |
| done_pulse | output | 1 | One-cycle pulse per completed transfer |
| err_pulse | output | 6 | One-cycle pulse per error class, bit order as in R3–R8 |
| err_sticky | output | 6 | Sticky error status, same bit order |
| xfer_count | output | CNT_W | Saturating count of completions |
| wait_count | output | CNT_W | Saturating count of wait cycles |

## Verification
The legal patterns are a zero-wait write, a read with two waits, and back-to-back transfers with no idle cycle. These show that a completion is recognised only when all three control lines are high, and that a setup cycle straight after a completion is legal. Each fault pattern is injected on its own: enable in the first select cycle, enable held after a completion (with and without select), a one-cycle transfer, an address change, write-data changes on a write and on a read, a bare enable, and select dropped in setup and in access. Each expected error vector isolates one class, or one known pair of classes. The clear-versus-set collision and a long run of transfers check the sticky-bit priority and counter saturation.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int ERR_N      = 6;
  localparam int E_EARLY    = 0;
  localparam int E_HOLD     = 1;
  localparam int E_UNSTABLE = 2;
  localparam int E_SHORT    = 3;
  localparam int E_NOSEL    = 4;
  localparam int E_DROP     = 5;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } phase_e;
endpackage

// File: rtl/pmon_tracker.sv
module pmon_tracker
  import pmon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              en,
  input  logic              rdy,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              complete,
  output logic              waiting,
  output logic [ERR_N-1:0]  viol
);
  phase_e            ph_q, ph_d;
  logic              done_q;
  logic              cap;
  logic              first;
  logic              mism;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  // Classify the current bus cycle against the tracked phase.
  always_comb begin
    first    = sel && (ph_q == PH_IDLE);
    complete = sel && en && rdy;
    waiting  = sel && en && !rdy;
    mism     = (addr != addr_q) || (wr != wr_q) || (wr_q && (wdata != wdata_q));

    viol             = '0;
    viol[E_EARLY]    = first && en && !done_q;
    viol[E_HOLD]     = done_q && en;
    viol[E_UNSTABLE] = (ph_q == PH_OPEN) && sel && mism;
    viol[E_SHORT]    = complete && (ph_q == PH_IDLE);
    viol[E_NOSEL]    = en && !sel;
    viol[E_DROP]     = (ph_q == PH_OPEN) && !sel;
  end

  // Next-phase decision and setup capture enable.
  always_comb begin
    ph_d = ph_q;
    cap  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (sel && !complete) begin
          ph_d = PH_OPEN;
          cap  = 1'b1;
        end
      end
      PH_OPEN: begin
        if (!sel || complete) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= complete;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap) begin
      addr_q  <= addr;
      wr_q    <= wr;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/pmon_err_bank.sv
module pmon_err_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] viol,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);
  for (genvar i = 0; i < N; i++) begin : g_cls
    logic pulse_q, sticky_q, sticky_d;

    always_comb begin
      sticky_d = sticky_q;
      if (clr)     sticky_d = 1'b0;
      if (viol[i]) sticky_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q  <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        pulse_q  <= viol[i];
        sticky_q <= sticky_d;
      end
    end

    assign pulse[i]  = pulse_q;
    assign sticky[i] = sticky_q;
  end
endmodule

// File: rtl/pmon_satcnt.sv
module pmon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  always_comb begin
    step  = inc && (cnt_q != TOP);
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/bus_phase_monitor.sv
module bus_phase_monitor
  import pmon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              en,
  input  logic              rdy,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_sticky,
  output logic              done_pulse,
  output logic [ERR_N-1:0]  err_pulse,
  output logic [ERR_N-1:0]  err_sticky,
  output logic [CNT_W-1:0]  xfer_count,
  output logic [CNT_W-1:0]  wait_count
);
  logic             complete, waiting;
  logic [ERR_N-1:0] viol;
  logic             done_q;

  pmon_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .rdy(rdy),
    .addr(addr), .wr(wr), .wdata(wdata),
    .complete(complete), .waiting(waiting), .viol(viol)
  );

  pmon_err_bank #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(clr_sticky), .viol(viol),
    .pulse(err_pulse), .sticky(err_sticky)
  );

  pmon_satcnt #(.W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .inc(complete), .count(xfer_count)
  );

  pmon_satcnt #(.W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .inc(waiting), .count(wait_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= complete;
  end

  assign done_pulse = done_q;
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker
  import pmon_pkg::*;
#(
  parameter int CW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             en,
  input logic             rdy,
  input logic             done_pulse,
  input logic [ERR_N-1:0] err_pulse,
  input logic [ERR_N-1:0] err_sticky,
  input logic [CW-1:0]    xfer_count,
  input logic [CW-1:0]    wait_count
);
  // R1
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(sel && en && rdy));

  // R1
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && en && rdy) |=> done_pulse);

  // R4
  held_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && en) |=> err_pulse[E_HOLD]);

  // R7
  bare_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel) |=> err_pulse[E_NOSEL]);

  // R9
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & ~err_sticky) == '0));

  // R10
  xfer_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_count >= $past(xfer_count));

  // R10
  wait_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_count >= $past(wait_count));
endmodule

bind bus_phase_monitor pmon_checker #(.CW(CNT_W)) u_pmon_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .rdy(rdy),
  .done_pulse(done_pulse), .err_pulse(err_pulse), .err_sticky(err_sticky),
  .xfer_count(xfer_count), .wait_count(wait_count)
);

// File: tb/tb_bus_phase_monitor.sv
module tb_bus_phase_monitor;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, en = 1'b0, rdy = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          done_pulse;
  logic [5:0]    err_pulse, err_sticky;
  logic [CW-1:0] xfer_count, wait_count;

  always #2 clk = ~clk;

  bus_phase_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .rdy(rdy),
    .addr(addr), .wr(wr), .wdata(wdata), .clr_sticky(clr),
    .done_pulse(done_pulse), .err_pulse(err_pulse), .err_sticky(err_sticky),
    .xfer_count(xfer_count), .wait_count(wait_count)
  );

  typedef struct {
    int         due;
    logic       done;
    logic [5:0] err;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  int    exp_x = 0, exp_w = 0;
  bit    fin = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one bus cycle and queues the expected registered result.
  task automatic drv(input logic s, input logic e, input logic r,
                     input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                     input logic xd, input logic [5:0] xe, input string tag,
                     input logic c = 1'b0);
    item_t it;
    @(posedge clk);
    #1;
    sel = s; en = e; rdy = r; addr = a; wr = w; wdata = d; clr = c;
    it.due = cyc + 1; it.done = xd; it.err = xe; it.tag = tag;
    sbq.push_back(it);
    if (xd) exp_x++;
    if (s && e && !r) exp_w++;  // R2 wait-cycle definition
  endtask

  task automatic idle(input string tag);
    drv(0, 0, 0, '0, 0, '0, 0, 6'h00, tag);
  endtask

  task automatic settle;
    @(posedge clk);
    #2;
  endtask

  // Monitor: pops and compares items as the design produces them.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        item_t it;
        it = sbq.pop_front();
        chk(done_pulse == it.done, it.tag, "done_pulse", done_pulse, it.done);
        chk(err_pulse == it.err, it.tag, "err_pulse", err_pulse, it.err);
      end
    end
  end

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 outputs during reset
    chk({done_pulse, err_pulse, err_sticky, xfer_count, wait_count} == '0,
        "R11", "outputs in reset", err_sticky, 0);
    rst_n = 1'b1;
    settle();
    chk({done_pulse, err_pulse, err_sticky, xfer_count, wait_count} == '0,
        "R11", "outputs after release", xfer_count, 0);
    idle("R11");

    // R1 zero-wait write
    drv(1, 0, 0, 16'h0010, 1, 32'h1111, 0, 6'h00, "R1");
    drv(1, 1, 1, 16'h0010, 1, 32'h1111, 1, 6'h00, "R1");
    idle("R1");
    // R2 read with two waits
    drv(1, 0, 0, 16'h0020, 0, 32'h0, 0, 6'h00, "R2");
    drv(1, 1, 0, 16'h0020, 0, 32'h0, 0, 6'h00, "R2");
    drv(1, 1, 0, 16'h0020, 0, 32'h0, 0, 6'h00, "R2");
    drv(1, 1, 1, 16'h0020, 0, 32'h0, 1, 6'h00, "R2");
    // R4 back-to-back: new setup right after completion is legal
    drv(1, 0, 0, 16'h0030, 1, 32'h3333, 0, 6'h00, "R4");
    drv(1, 1, 1, 16'h0030, 1, 32'h3333, 1, 6'h00, "R4");
    drv(1, 0, 0, 16'h0031, 0, 32'h0, 0, 6'h00, "R4");
    drv(1, 1, 1, 16'h0031, 0, 32'h0, 1, 6'h00, "R4");
    idle("R4");
    settle();
    chk(xfer_count == 4, "R10", "xfer_count", xfer_count, 4);
    chk(wait_count == 2, "R2", "wait_count", wait_count, 2);

    // R3 early enable, then a normal access completes cleanly
    drv(1, 1, 0, 16'h0040, 0, 32'h0, 0, 6'h01, "R3");
    drv(1, 1, 1, 16'h0040, 0, 32'h0, 1, 6'h00, "R3");
    idle("R3");
    // R4 enable held after completion, with select and without
    drv(1, 0, 0, 16'h0050, 0, 32'h0, 0, 6'h00, "R4");
    drv(1, 1, 1, 16'h0050, 0, 32'h0, 1, 6'h00, "R4");
    drv(1, 1, 0, 16'h0050, 0, 32'h0, 0, 6'h02, "R4");
    drv(1, 1, 1, 16'h0050, 0, 32'h0, 1, 6'h00, "R4");
    drv(0, 1, 0, 16'h0050, 0, 32'h0, 0, 6'h12, "R4 R7");
    idle("R4");
    // R6 one-cycle transfer (also early enable)
    drv(1, 1, 1, 16'h0060, 0, 32'h0, 1, 6'h09, "R6");
    idle("R6");
    // R5 address change in access
    drv(1, 0, 0, 16'h0070, 0, 32'h0, 0, 6'h00, "R5");
    drv(1, 1, 0, 16'h0071, 0, 32'h0, 0, 6'h04, "R5");
    drv(1, 1, 1, 16'h0070, 0, 32'h0, 1, 6'h00, "R5");
    idle("R5");
    // R5 write data change on a write, then ignored on a read
    drv(1, 0, 0, 16'h0080, 1, 32'hAAAA, 0, 6'h00, "R5");
    drv(1, 1, 0, 16'h0080, 1, 32'hBBBB, 0, 6'h04, "R5");
    drv(1, 1, 1, 16'h0080, 1, 32'hAAAA, 1, 6'h00, "R5");
    drv(1, 0, 0, 16'h0081, 0, 32'h1234, 0, 6'h00, "R5 read");
    drv(1, 1, 0, 16'h0081, 0, 32'h5678, 0, 6'h00, "R5 read");
    drv(1, 1, 1, 16'h0081, 0, 32'h9ABC, 1, 6'h00, "R5 read");
    idle("R5");
    // R7 bare enable
    drv(0, 1, 0, 16'h0000, 0, 32'h0, 0, 6'h10, "R7");
    idle("R7");
    // R8 select dropped after setup and during access
    drv(1, 0, 0, 16'h0090, 0, 32'h0, 0, 6'h00, "R8");
    drv(0, 0, 0, 16'h0090, 0, 32'h0, 0, 6'h20, "R8");
    drv(1, 0, 0, 16'h0091, 0, 32'h0, 0, 6'h00, "R8");
    drv(1, 1, 0, 16'h0091, 0, 32'h0, 0, 6'h00, "R8");
    drv(0, 0, 0, 16'h0091, 0, 32'h0, 0, 6'h20, "R8");
    idle("R8");
    settle();
    chk(err_sticky == 6'h3F, "R9", "sticky all classes", err_sticky, 6'h3F);

    // R9 clear, then clear colliding with a new error
    drv(0, 0, 0, '0, 0, '0, 0, 6'h00, "R9", 1'b1);
    settle();
    chk(err_sticky == 6'h00, "R9", "sticky after clear", err_sticky, 0);
    drv(0, 1, 0, '0, 0, '0, 0, 6'h10, "R9 R7", 1'b1);
    settle();
    chk(err_sticky == 6'h10, "R9", "set wins over clear", err_sticky, 6'h10);
    idle("R9");

    // R10 saturation of both counters
    for (int i = 0; i < 20; i++) begin
      drv(1, 0, 0, 16'h0100, 0, 32'h0, 0, 6'h00, "R10");
      drv(1, 1, 0, 16'h0100, 0, 32'h0, 0, 6'h00, "R10");
      drv(1, 1, 1, 16'h0100, 0, 32'h0, 1, 6'h00, "R10");
    end
    idle("R10");
    settle();
    chk(xfer_count == ((exp_x > SAT) ? SAT : exp_x), "R10", "xfer_count sat", xfer_count, SAT);
    chk(wait_count == ((exp_w > SAT) ? SAT : exp_w), "R10", "wait_count sat", wait_count, SAT);

    repeat (3) @(posedge clk);
    #3;
    chk(sbq.size() == 0, "R1", "scoreboard drained", sbq.size(), 0);
    fin = 1;
    summary();
    $finish;
  end
endmodule